// File: doc/BRIEF.md
# NAND Asynchronous Bus Bridge

This block connects a simple memory-mapped host port to an 8-bit asynchronous NAND flash bus. The host issues plain reads and writes. In the flash window, host address bits pick the cycle type: one bit raises the address latch enable, a higher bit raises the command latch enable, and a configurable bit steers the access to a secondary chip enable for a second die. Command, address and data cycles therefore differ only in their address offset. The host port stalls on a request/ready handshake until the whole bus sequence has finished.

Every bus byte runs through a setup phase, an active-low strobe phase and a hold phase. Each phase length comes from a field of a packed timing word, with separate fields for reads and writes. A turnaround phase closes the access before the host sees ready. Halfword and word host accesses become two or four byte strobes, lowest byte first. A small register window holds the timing word and a per-chip-select flash-mode control. It also exposes the shared, wire-AND ready/busy line as a status bit.

Top module: `nand_async_bridge`

## Requirements
- R1: After reset, every chip enable, `nand_we_n` and `nand_re_n` are high, both latch enables, `nand_dq_oe` and `host_ready` are low, and the timing and control registers read as zero.
- R2: When host_addr[15] is 1 the access targets registers, selected by host_addr[3:2]. Index 0 is the timing word, readable and writable in all 32 bits. Index 1 is the control register, writable, with bits [3:0] kept and all other bits reading 0. Index 2 is read-only status.
- R3: A flash-window access (host_addr[15]=0) made while control bit CS_ID (default 0) is 0 drives no strobe, leaves both chip enables high, still completes, and a read returns 0.
- R4: host_addr[4] set raises `nand_cle`. Otherwise host_addr[3] set raises `nand_ale`. When both bits are set only `nand_cle` rises. host_addr[1:0] have no effect.
- R5: host_addr[5] set selects `nand_ce2_n` in place of `nand_ce_n`. The two are never low together.
- R6: In a write, byte setup lasts timing[29:26]+1 cycles, the `nand_we_n` low strobe lasts timing[25:20]+1 cycles and hold lasts timing[19:17]+1 cycles. The data bus holds steady during the strobe.
- R7: In a read, setup lasts timing[16:13]+1 cycles, the `nand_re_n` strobe lasts timing[12:7]+1 cycles and hold lasts timing[6:4]+1 cycles. The byte on `nand_dq_in` is captured in the last strobe cycle.
- R8: After the last hold, the chip enable rises and timing[3:2]+1 turnaround cycles pass before `host_ready` rises.
- R9: host_size 0, 1 and 2 give 1, 2 and 4 byte strobes, and 3 acts as 2. Byte k of the access travels in host data bits [8k+7:8k], with byte 0 first.
- R10: Status bit 0 reads the `nand_rdy` input (1 ready, 0 busy) through a two-stage synchronizer. Status bits [31:1] read 0.
- R11: Chip enable and latch enables stay asserted across all bytes of one access. `nand_we_n` and `nand_re_n` are never low together. `nand_dq_oe` is high only in write accesses.
- R12: `host_ready` is a one-cycle pulse. A register access completes in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request, held until host_ready |
| host_we | input | 1 | 1 write, 0 read |
| host_addr | input | 16 | Byte address (bit 15 selects registers) |
| host_size | input | 2 | 0 byte, 1 halfword, 2 word |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_ready |
| host_ready | output | 1 | Completion pulse |
| nand_ce_n | output | 1 | Primary chip enable, active low |
| nand_ce2_n | output | 1 | Secondary chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven to the flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Byte returned by the flash |
| nand_rdy | input | 1 | Shared wire-AND ready/busy |

## Verification
The assertions check signal relations that must hold on every cycle. The two strobes never overlap, a strobe only occurs inside an active chip enable, the chip enables and latch enables are mutually exclusive, the bus stays quiet while flash mode is off, the output enable never coincides with a read strobe, write data stays steady during a strobe, and ready lasts one cycle. Phase lengths against programmed fields, byte order across a split access, read capture, latch decoding priority, register readback and the synchronized status value need known stimulus and expected counts. A flash-side monitor in the bench measures these in each directed scenario.

// File: rtl/nab_pkg.sv
// Shared types and helpers for the NAND asynchronous bus bridge.
// Assumes a 32-bit timing word with write, read and turnaround fields.
package nab_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_TURN,
        PH_DONE
    } phase_t;

    // Phase lengths for one transfer direction, each encoding N+1 cycles.
    typedef struct packed {
        logic [3:0] setup;
        logic [5:0] strobe;
        logic [2:0] hold;
    } dir_timing_t;

    localparam int unsigned CNT_W = 6;

    // Pull the write or read phase fields out of the timing word.
    function automatic dir_timing_t pick_timing(input logic [31:0] tw, input logic is_write);
        dir_timing_t t;
        if (is_write) begin
            t.setup  = tw[29:26];
            t.strobe = tw[25:20];
            t.hold   = tw[19:17];
        end else begin
            t.setup  = tw[16:13];
            t.strobe = tw[12:7];
            t.hold   = tw[6:4];
        end
        return t;
    endfunction

    // Index of the final byte for a host access size code.
    function automatic logic [1:0] last_byte(input logic [1:0] size);
        case (size)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            2'd3:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/nab_decode.sv
// Address decoder: splits the host address into register selection and
// the flash latch/chip-enable controls. Purely combinational.
// Assumes command-latch priority over address-latch.
module nab_decode #(
    parameter int ADDR_W  = 16,
    parameter int ALE_BIT = 3,
    parameter int CLE_BIT = 4,
    parameter int CS2_BIT = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_reg,
    output logic [1:0]        reg_sel,
    output logic              cle,
    output logic              ale,
    output logic              sec_cs
);
    localparam int REG_BIT = ADDR_W - 1;

    logic unused_addr_bits;

    // Decode window, register index and latch requests.
    always_comb begin
        is_reg  = addr[REG_BIT];
        reg_sel = addr[3:2];
        cle     = addr[CLE_BIT];
        ale     = addr[ALE_BIT] & ~addr[CLE_BIT];
        sec_cs  = addr[CS2_BIT];
    end

    assign unused_addr_bits = ^addr;
endmodule

// File: rtl/nab_regs.sv
// Register file: timing word, flash-mode control bits, synchronized
// ready/busy status. Writes happen when wr_en is high at a clock edge.
// Assumes nand_rdy is asynchronous to clk.
module nab_regs #(
    parameter int          CS_COUNT   = 4,
    parameter logic [31:0] TIMING_RST = 32'h0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          sel,
    input  logic [31:0]         wr_data,
    input  logic                rdy_async,
    output logic [31:0]         timing_word,
    output logic [CS_COUNT-1:0] ctrl_bits,
    output logic [31:0]         rd_data
);
    logic rdy_meta;
    logic rdy_sync;
    logic unused_wr_bits;

    // Two-stage synchronizer for the shared ready/busy line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_meta <= 1'b0;
            rdy_sync <= 1'b0;
        end else begin
            rdy_meta <= rdy_async;
            rdy_sync <= rdy_meta;
        end
    end

    // Writable timing and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_word <= TIMING_RST;
            ctrl_bits   <= '0;
        end else if (wr_en) begin
            if (sel == 2'd0) timing_word <= wr_data;
            if (sel == 2'd1) ctrl_bits   <= wr_data[CS_COUNT-1:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        case (sel)
            2'd0:    rd_data = timing_word;
            2'd1:    rd_data = {{(32-CS_COUNT){1'b0}}, ctrl_bits};
            2'd2:    rd_data = {31'b0, rdy_sync};
            default: rd_data = '0;
        endcase
    end

    assign unused_wr_bits = ^wr_data;
endmodule

// File: rtl/nab_sequencer.sv
// Access sequencer: accepts one host request, then either completes a
// register access or runs setup/strobe/hold per byte plus a final
// turnaround on the flash bus. Outputs decode from registered state.
// Assumes the host holds its request steady until host_ready.
module nab_sequencer
    import nab_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [1:0]  host_size,
    input  logic [31:0] host_wdata,
    input  logic        is_reg,
    input  logic        cle_req,
    input  logic        ale_req,
    input  logic        sec_req,
    input  logic        mode_on,
    input  logic [31:0] timing_word,
    input  logic [31:0] reg_rdata,
    input  logic [7:0]  nand_dq_in,
    output logic        reg_wr_en,
    output logic        host_ready,
    output logic [31:0] host_rdata,
    output logic        nand_ce_n,
    output logic        nand_ce2_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_out,
    output logic        nand_dq_oe
);
    phase_t           state;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       byte_idx;
    logic [1:0]       last_idx;
    logic             we_q, cle_q, ale_q, sec_q;
    logic [31:0]      wdata_q;
    logic [31:0]      rdata_q;
    logic             accept;
    logic             in_acc;
    dir_timing_t      acc_tmg;
    dir_timing_t      run_tmg;
    logic             unused_tw_bits;

    assign accept  = (state == PH_IDLE) && host_req;
    assign acc_tmg = pick_timing(timing_word, host_we);
    assign run_tmg = pick_timing(timing_word, we_q);
    assign reg_wr_en = accept && is_reg && host_we;

    // Phase state machine with per-phase down counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PH_IDLE;
            cnt      <= '0;
            byte_idx <= '0;
            last_idx <= '0;
            we_q     <= 1'b0;
            cle_q    <= 1'b0;
            ale_q    <= 1'b0;
            sec_q    <= 1'b0;
            wdata_q  <= '0;
            rdata_q  <= '0;
        end else begin
            case (state)
                PH_IDLE: if (host_req) begin
                    we_q     <= host_we;
                    cle_q    <= cle_req;
                    ale_q    <= ale_req;
                    sec_q    <= sec_req;
                    wdata_q  <= host_wdata;
                    byte_idx <= '0;
                    last_idx <= last_byte(host_size);
                    if (is_reg) begin
                        rdata_q <= host_we ? 32'h0 : reg_rdata;
                        state   <= PH_DONE;
                    end else if (!mode_on) begin
                        rdata_q <= '0;
                        state   <= PH_DONE;
                    end else begin
                        rdata_q <= '0;
                        cnt     <= {2'b00, acc_tmg.setup};
                        state   <= PH_SETUP;
                    end
                end
                PH_SETUP: if (cnt == '0) begin
                    cnt   <= run_tmg.strobe;
                    state <= PH_STROBE;
                end else cnt <= cnt - 1'b1;
                PH_STROBE: if (cnt == '0) begin
                    if (!we_q) rdata_q[{byte_idx, 3'b000} +: 8] <= nand_dq_in;
                    cnt   <= {3'b000, run_tmg.hold};
                    state <= PH_HOLD;
                end else cnt <= cnt - 1'b1;
                PH_HOLD: if (cnt == '0) begin
                    if (byte_idx == last_idx) begin
                        cnt   <= {4'b0000, timing_word[3:2]};
                        state <= PH_TURN;
                    end else begin
                        byte_idx <= byte_idx + 1'b1;
                        cnt      <= {2'b00, run_tmg.setup};
                        state    <= PH_SETUP;
                    end
                end else cnt <= cnt - 1'b1;
                PH_TURN: if (cnt == '0) state <= PH_DONE;
                         else cnt <= cnt - 1'b1;
                PH_DONE: state <= PH_IDLE;
                default: state <= PH_IDLE;
            endcase
        end
    end

    // Bus pins decoded from the registered phase.
    always_comb begin
        in_acc      = (state == PH_SETUP) || (state == PH_STROBE) || (state == PH_HOLD);
        nand_ce_n   = !(in_acc && !sec_q);
        nand_ce2_n  = !(in_acc && sec_q);
        nand_cle    = in_acc && cle_q;
        nand_ale    = in_acc && ale_q;
        nand_we_n   = !((state == PH_STROBE) && we_q);
        nand_re_n   = !((state == PH_STROBE) && !we_q);
        nand_dq_oe  = in_acc && we_q;
        nand_dq_out = wdata_q[{byte_idx, 3'b000} +: 8];
        host_ready  = (state == PH_DONE);
        host_rdata  = rdata_q;
    end

    assign unused_tw_bits = ^{timing_word[31:30], timing_word[1:0]};
endmodule

// File: rtl/nand_async_bridge.sv
// Top level: host port to 8-bit asynchronous NAND bus bridge.
// Joins the address decoder, register file and access sequencer.
// Assumes one bridge instance serves chip select CS_ID.
module nand_async_bridge #(
    parameter int          ADDR_W     = 16,
    parameter int          CS_COUNT   = 4,
    parameter int          CS_ID      = 0,
    parameter int          ALE_BIT    = 3,
    parameter int          CLE_BIT    = 4,
    parameter int          CS2_BIT    = 5,
    parameter logic [31:0] TIMING_RST = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_size,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_ready,
    output logic              nand_ce_n,
    output logic              nand_ce2_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_in,
    input  logic              nand_rdy
);
    logic                is_reg, cle_req, ale_req, sec_req;
    logic [1:0]          reg_sel;
    logic                reg_wr_en;
    logic [31:0]         timing_word, reg_rdata;
    logic [CS_COUNT-1:0] ctrl_bits;
    logic                mode_on;

    assign mode_on = ctrl_bits[CS_ID];

    nab_decode #(
        .ADDR_W(ADDR_W), .ALE_BIT(ALE_BIT), .CLE_BIT(CLE_BIT), .CS2_BIT(CS2_BIT)
    ) u_decode (
        .addr(host_addr), .is_reg(is_reg), .reg_sel(reg_sel),
        .cle(cle_req), .ale(ale_req), .sec_cs(sec_req)
    );

    nab_regs #(.CS_COUNT(CS_COUNT), .TIMING_RST(TIMING_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(reg_sel),
        .wr_data(host_wdata), .rdy_async(nand_rdy), .timing_word(timing_word),
        .ctrl_bits(ctrl_bits), .rd_data(reg_rdata)
    );

    nab_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_size(host_size), .host_wdata(host_wdata), .is_reg(is_reg),
        .cle_req(cle_req), .ale_req(ale_req), .sec_req(sec_req), .mode_on(mode_on),
        .timing_word(timing_word), .reg_rdata(reg_rdata), .nand_dq_in(nand_dq_in),
        .reg_wr_en(reg_wr_en), .host_ready(host_ready), .host_rdata(host_rdata),
        .nand_ce_n(nand_ce_n), .nand_ce2_n(nand_ce2_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe)
    );
endmodule

// File: rtl/nab_checker.sv
// Cycle-by-cycle protocol checks for the NAND bridge, bound to the top.
module nab_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_on,
    input logic       host_ready,
    input logic       nand_ce_n,
    input logic       nand_ce2_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic [7:0] nand_dq_out,
    input logic       nand_dq_oe
);
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    p_strobe_in_ce_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> (!nand_ce_n || !nand_ce2_n));

    p_one_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_ce_n && !nand_ce2_n));

    p_latch_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_mode_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_on |-> (nand_ce_n && nand_ce2_n));

    p_oe_no_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        nand_dq_oe |-> nand_re_n);

    p_wdata_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && !$past(nand_we_n)) |-> $stable(nand_dq_out));

    p_ready_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);
endmodule

bind nand_async_bridge nab_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mode_on(mode_on), .host_ready(host_ready),
    .nand_ce_n(nand_ce_n), .nand_ce2_n(nand_ce2_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe)
);

// File: tb/tb_nand_async_bridge.sv
// Directed bench with a flash-side monitor that measures phase lengths.
module tb_nand_async_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [15:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready;
    logic        nand_ce_n, nand_ce2_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic [7:0]  nand_dq_out, nand_dq_in;
    logic        nand_dq_oe;
    logic        nand_rdy = 1'b1;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    nand_async_bridge dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ready(host_ready), .nand_ce_n(nand_ce_n),
        .nand_ce2_n(nand_ce2_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rdy(nand_rdy)
    );

    // ---------------- flash-side monitor and read model ----------------
    int   n_str, hi_run, lo_run, tail, turn_run, n_close;
    int   gaps[4];
    int   slen[4];
    logic [7:0] wbytes[4];
    bit   cle_s[4], ale_s[4];
    bit   in_str, closed, pri_seen, sec_seen, oe_in_read, ce_ever;
    logic [7:0] rd_mem[4];
    int   rd_idx;

    assign nand_dq_in = rd_mem[rd_idx[1:0]];

    task automatic mon_clear();
        n_str = 0; hi_run = 0; lo_run = 0; tail = 0; turn_run = 0; n_close = 0;
        in_str = 0; closed = 0; pri_seen = 0; sec_seen = 0; oe_in_read = 0;
        ce_ever = 0; rd_idx = 0;
        for (int i = 0; i < 4; i++) begin
            gaps[i] = 0; slen[i] = 0; wbytes[i] = 8'h00; cle_s[i] = 0; ale_s[i] = 0;
        end
    endtask

    always @(negedge clk) begin
        bit active, strobe;
        active = !nand_ce_n || !nand_ce2_n;
        strobe = !nand_we_n || !nand_re_n;
        if (!nand_re_n && nand_dq_oe) oe_in_read = 1;
        if (active) begin
            ce_ever = 1;
            if (!nand_ce_n) pri_seen = 1;
            if (!nand_ce2_n) sec_seen = 1;
            if (strobe) begin
                if (!in_str) begin
                    if (n_str < 4) begin
                        gaps[n_str] = hi_run; wbytes[n_str] = nand_dq_out;
                        cle_s[n_str] = nand_cle; ale_s[n_str] = nand_ale;
                    end
                    in_str = 1; lo_run = 1; hi_run = 0;
                end else lo_run++;
            end else begin
                if (in_str) begin
                    if (n_str < 4) slen[n_str] = lo_run;
                    n_str++; in_str = 0; hi_run = 1; rd_idx++;
                end else hi_run++;
            end
        end else begin
            if (ce_ever && !closed) begin
                tail = hi_run; closed = 1; n_close++;
            end
            if (closed && !host_ready) turn_run++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_tw(input int ws, wst, wh, rs, rst, rh, tr);
        logic [31:0] w;
        w = '0;
        w[29:26] = ws[3:0]; w[25:20] = wst[5:0]; w[19:17] = wh[2:0];
        w[16:13] = rs[3:0]; w[12:7] = rst[5:0]; w[6:4] = rh[2:0]; w[3:2] = tr[1:0];
        return w;
    endfunction

    bit pulse_ok;

    task automatic xfer(input logic we, input logic [15:0] addr, input logic [1:0] size,
                        input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        host_req = 1; host_we = we; host_addr = addr; host_size = size; host_wdata = wd;
        do @(negedge clk); while (!host_ready);
        rd = host_rdata;
        host_req = 0;
        @(negedge clk);
        pulse_ok = !host_ready;
    endtask

    localparam logic [15:0] A_TIM  = 16'h8000;
    localparam logic [15:0] A_CTRL = 16'h8004;
    localparam logic [15:0] A_STAT = 16'h8008;

    // Check shape of a completed flash access.
    task automatic chk_shape(input string req, input int nb, input int s, input int st,
                             input int h, input int t);
        chk(n_str == nb, {req, " strobe count"}, n_str, nb);
        chk(n_close == 1, "R11 chip enable held across access", n_close, 1);
        chk(gaps[0] == s + 1, {req, " first setup"}, gaps[0], s + 1);
        for (int i = 0; i < nb && i < 4; i++)
            chk(slen[i] == st + 1, {req, " strobe length"}, slen[i], st + 1);
        for (int i = 1; i < nb && i < 4; i++)
            chk(gaps[i] == h + 1 + s + 1, {req, " hold+setup gap"}, gaps[i], h + s + 2);
        chk(tail == h + 1, {req, " last hold"}, tail, h + 1);
        chk(turn_run == t + 1, "R8 turnaround cycles", turn_run, t + 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] rd;
        chk(nand_ce_n && nand_ce2_n && nand_we_n && nand_re_n, "R1 strobes idle high",
            {nand_ce_n, nand_ce2_n, nand_we_n, nand_re_n}, 4'hF);
        chk(!nand_cle && !nand_ale && !nand_dq_oe && !host_ready, "R1 enables low",
            {nand_cle, nand_ale, nand_dq_oe, host_ready}, 0);
        xfer(0, A_TIM, 2, 0, rd);  chk(rd == 0, "R1 timing reset", rd, 0);
        xfer(0, A_CTRL, 2, 0, rd); chk(rd == 0, "R1 control reset", rd, 0);
    endtask

    task automatic t_regs();
        logic [31:0] rd;
        xfer(1, A_TIM, 2, 32'hDEAD_BEEF, rd);
        chk(pulse_ok, "R12 ready one cycle", 0, 1);
        xfer(0, A_TIM, 2, 0, rd);  chk(rd == 32'hDEAD_BEEF, "R2 timing readback", rd, 32'hDEAD_BEEF);
        xfer(1, A_CTRL, 2, 32'hFFFF_FFF0, rd);
        xfer(0, A_CTRL, 2, 0, rd); chk(rd == 0, "R2 control upper bits", rd, 0);
        xfer(1, A_CTRL, 2, 32'hFFFF_FFFA, rd);
        xfer(0, A_CTRL, 2, 0, rd); chk(rd == 32'hA, "R2 control readback", rd, 32'hA);
    endtask

    task automatic t_mode_off();
        logic [31:0] rd;
        xfer(1, A_CTRL, 2, 32'h0, rd);
        mon_clear();
        xfer(1, 16'h0010, 0, 32'h70, rd);
        chk(!ce_ever && n_str == 0, "R3 no bus activity write", n_str, 0);
        rd_mem[0] = 8'h5A;
        mon_clear();
        xfer(0, 16'h0000, 2, 0, rd);
        chk(!ce_ever && rd == 0, "R3 read returns zero", rd, 0);
    endtask

    task automatic t_write_cmd_addr();
        logic [31:0] rd;
        xfer(1, A_TIM, 2, mk_tw(2, 3, 1, 0, 0, 0, 2), rd);
        xfer(1, A_CTRL, 2, 32'h1, rd);
        mon_clear();
        xfer(1, 16'h0010, 0, 32'h0000_0070, rd);
        chk_shape("R6", 1, 2, 3, 1, 2);
        chk(wbytes[0] == 8'h70, "R6 command byte", wbytes[0], 8'h70);
        chk(cle_s[0] && !ale_s[0] && pri_seen && !sec_seen, "R4 CLE only", {cle_s[0], ale_s[0]}, 2);
        mon_clear();
        xfer(1, 16'h000B, 0, 32'h0000_0033, rd);
        chk(!cle_s[0] && ale_s[0], "R4 ALE with low bits set", {cle_s[0], ale_s[0]}, 1);
        chk(wbytes[0] == 8'h33, "R4 address byte", wbytes[0], 8'h33);
        mon_clear();
        xfer(1, 16'h0018, 0, 32'h0000_0011, rd);
        chk(cle_s[0] && !ale_s[0], "R4 CLE priority", {cle_s[0], ale_s[0]}, 2);
    endtask

    task automatic t_split_write();
        logic [31:0] rd;
        xfer(1, A_TIM, 2, mk_tw(1, 2, 3, 0, 0, 0, 0), rd);
        mon_clear();
        xfer(1, 16'h0000, 2, 32'h1122_3344, rd);
        chk_shape("R9", 4, 1, 2, 3, 0);
        chk({wbytes[3], wbytes[2], wbytes[1], wbytes[0]} == 32'h1122_3344, "R9 word byte order",
            {wbytes[3], wbytes[2], wbytes[1], wbytes[0]}, 32'h1122_3344);
        chk(!cle_s[1] && !ale_s[3], "R11 data cycles no latch", {cle_s[1], ale_s[3]}, 0);
        mon_clear();
        xfer(1, 16'h0000, 1, 32'hAAAA_BEEF, rd);
        chk(n_str == 2 && wbytes[0] == 8'hEF && wbytes[1] == 8'hBE, "R9 halfword split",
            {n_str[7:0], wbytes[1], wbytes[0]}, 32'h02BEEF);
        mon_clear();
        xfer(1, 16'h0000, 3, 32'h0, rd);
        chk(n_str == 2, "R9 size 3 acts as halfword", n_str, 2);
    endtask

    task automatic t_read();
        logic [31:0] rd;
        xfer(1, A_TIM, 2, mk_tw(0, 0, 0, 1, 2, 0, 1), rd);
        rd_mem[0] = 8'hA1; rd_mem[1] = 8'hB2; rd_mem[2] = 8'hC3; rd_mem[3] = 8'hD4;
        mon_clear();
        xfer(0, 16'h0000, 2, 0, rd);
        chk_shape("R7", 4, 1, 2, 0, 1);
        chk(rd == 32'hD4C3_B2A1, "R7 read word assembled", rd, 32'hD4C3_B2A1);
        chk(!oe_in_read, "R11 no output enable in read", oe_in_read, 0);
        mon_clear();
        xfer(0, 16'h0000, 0, 0, rd);
        chk(rd == 32'h0000_00A1, "R7 read byte", rd, 32'hA1);
    endtask

    task automatic t_secondary();
        logic [31:0] rd;
        mon_clear();
        xfer(1, 16'h0030, 0, 32'h90, rd);
        chk(sec_seen && !pri_seen, "R5 secondary chip enable", {sec_seen, pri_seen}, 2);
        chk(cle_s[0] && wbytes[0] == 8'h90, "R5 command reaches second die", wbytes[0], 8'h90);
    endtask

    task automatic t_status();
        logic [31:0] rd;
        nand_rdy = 0;
        repeat (4) @(negedge clk);
        xfer(0, A_STAT, 2, 0, rd); chk(rd == 0, "R10 busy reads 0", rd, 0);
        nand_rdy = 1;
        repeat (4) @(negedge clk);
        xfer(0, A_STAT, 2, 0, rd); chk(rd == 1, "R10 ready reads 1", rd, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        mon_clear();
        rd_mem[0] = 0; rd_mem[1] = 0; rd_mem[2] = 0; rd_mem[3] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_mode_off();
        t_write_cmd_addr();
        t_split_write();
        t_read();
        t_secondary();
        t_status();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule